// File: doc/BRIEF.md
# Bit-Chained Serial Delay over a Byte-Wide SRAM

This block turns an ordinary byte-wide asynchronous SRAM with a shared bidirectional data bus into a long one-bit delay line. Every bit period it visits one address. It reads the stored byte and captures it in a holding register. It then writes back a byte whose bottom lane carries the new serial input bit and whose other lanes carry the captured lanes moved up by one. A bit entering lane 0 therefore climbs one lane on each visit to its address. After eight visits it leaves from the top lane as the serial output. The delay is eight times the programmed address depth, and no external shift registers are needed.

A single sequencer steps through five named states: `ST_IDLE`, `ST_READ`, `ST_CAPTURE`, `ST_TURN` and `ST_WRITE`. In `ST_IDLE` it waits for the bit-clock enable (transition *start*). It then holds output-enable for a read slot (`ST_READ` to `ST_CAPTURE`). The holding register loads as it leaves `ST_CAPTURE` (transition *capture*). Next comes one idle bus cycle (`ST_TURN` to `ST_WRITE`), then a one-cycle write pulse with the bus driven. The sequencer returns to `ST_IDLE` while the address counter steps (transition *advance*). The output stays zero until the memory holds only data written since reset.

Top module: `bitchain_delay`

## Requirements
- R1: While reset is held and just after it is released, mem_oe_n and mem_we_n are 1, mem_addr is 0 and ser_out is 0.
- R2: A bit_en high in ST_IDLE starts one step. For the next two cycles mem_oe_n is 0 with mem_we_n 1. Then one cycle has both strobes at 1. Then one cycle has mem_we_n at 0 and mem_oe_n at 1. The block is then idle again with both strobes at 1.
- R3: The byte driven on mem_dq during the write cycle has bit 0 equal to ser_in as sampled with bit_en. Bit n+1 equals bit n of the byte read in the same step, for n = 0 to 6.
- R4: The read and the write of a step use the same mem_addr. After the write, mem_addr becomes mem_addr+1, or 0 when mem_addr was at least depth_m1. It does not change at any other time.
- R5: Once filling has ended, ser_out equals bit 7 of the byte read in the current step. It is valid from the turnaround cycle and holds until the next step's capture.
- R6: ser_out is 0 for every step until the address counter has wrapped eight times since reset, whatever the memory held.
- R7: The bit presented on ser_out in step k equals the ser_in bit of step k - 8*(depth_m1+1).
- R8: A bit_en that is high while a step is in progress starts no extra step. A change of ser_in after the starting cycle does not alter the written byte.
- R9: mem_oe_n and mem_we_n are never 0 together, and the block drives mem_dq only during the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per serial bit period |
| ser_in | input | 1 | Serial input bit, sampled with bit_en |
| depth_m1 | input | ADDR_W | Address depth minus one (kept static between resets) |
| ser_out | output | 1 | Delayed serial output bit |
| mem_addr | output | ADDR_W | SRAM address |
| mem_dq | inout | LANES | SRAM bidirectional data bus |
| mem_oe_n | output | 1 | SRAM output enable, active low |
| mem_we_n | output | 1 | SRAM write enable, active low |

## Verification
A single one-bit impulse at depth four shows whether the delay is exactly eight depths and not one step off. An alternating pattern at depth one separates lane shifts from address steps, because an off-by-one lane move inverts every output bit. A long pseudo-random sequence at depth seven exercises every lane with mixed data. The memory starts filled with ones, so the zero-gating during fill is actually tested against garbage. One step holds bit_en for two cycles and flips ser_in in the second. This shows that a late strobe adds no step and that the late input change has no effect.

// File: rtl/bitchain_pkg.sv
package bitchain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ    = 3'd1,
        ST_CAPTURE = 3'd2,
        ST_TURN    = 3'd3,
        ST_WRITE   = 3'd4
    } step_state_t;

endpackage

// File: rtl/bitchain_addr_gen.sv
module bitchain_addr_gen #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [ADDR_W-1:0] depth_m1,
    output logic [ADDR_W-1:0] addr,
    output logic              filled
);
    localparam int WRAP_W = $clog2(LANES + 1);
    localparam logic [WRAP_W-1:0] WRAP_FULL = WRAP_W'(LANES);

    logic [WRAP_W-1:0] wrap_cnt;
    logic              at_last;

    assign at_last = (addr >= depth_m1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (adv) begin
            addr <= at_last ? '0 : addr + 1'b1;
        end
    end

    // Counts wraps up to LANES; each bit then present has made all lane trips.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_cnt <= '0;
        end else if (adv && at_last && (wrap_cnt != WRAP_FULL)) begin
            wrap_cnt <= wrap_cnt + 1'b1;
        end
    end

    assign filled = (wrap_cnt == WRAP_FULL);

endmodule

// File: rtl/bitchain_lane_latch.sv
module bitchain_lane_latch #(
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic             fill_done,
    input  logic             in_bit,
    input  logic [LANES-1:0] rd_data,
    output logic [LANES-1:0] wr_data,
    output logic             tap_out
);
    localparam int TOP = LANES - 1;

    logic [LANES-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            tap_out <= 1'b0;
        end else if (cap) begin
            hold_q  <= rd_data;
            tap_out <= fill_done & rd_data[TOP];
        end
    end

    // Lane 0 takes the fresh bit; each higher lane takes the lane below it.
    assign wr_data[0] = in_bit;
    for (genvar g = 1; g < LANES; g++) begin : g_lane
        assign wr_data[g] = hold_q[g-1];
    end

endmodule

// File: rtl/bitchain_seq.sv
module bitchain_seq
    import bitchain_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_en,
    input  logic        ser_in,
    output step_state_t state,
    output logic        in_bit,
    output logic        oe_n,
    output logic        we_n,
    output logic        drive,
    output logic        cap,
    output logic        adv
);
    step_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (bit_en) nxt = ST_READ;
            ST_READ:    nxt = ST_CAPTURE;
            ST_CAPTURE: nxt = ST_TURN;
            ST_TURN:    nxt = ST_WRITE;
            ST_WRITE:   nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_bit <= 1'b0;
        end else if (state == ST_IDLE && bit_en) begin
            in_bit <= ser_in;
        end
    end

    always_comb begin
        oe_n  = 1'b1;
        we_n  = 1'b1;
        drive = 1'b0;
        cap   = 1'b0;
        adv   = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_READ:    oe_n = 1'b0;
            ST_CAPTURE: begin
                oe_n = 1'b0;
                cap  = 1'b1;
            end
            ST_TURN:    ;
            ST_WRITE:   begin
                we_n  = 1'b0;
                drive = 1'b1;
                adv   = 1'b1;
            end
            default:    ;
        endcase
    end

endmodule

// File: rtl/bitchain_delay.sv
module bitchain_delay
    import bitchain_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              ser_in,
    input  logic [ADDR_W-1:0] depth_m1,
    output logic              ser_out,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [LANES-1:0]  mem_dq,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    step_state_t      state;
    logic             in_bit;
    logic             drive;
    logic             cap;
    logic             adv;
    logic             filled;
    logic [LANES-1:0] wr_data;

    bitchain_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .ser_in (ser_in),
        .state  (state),
        .in_bit (in_bit),
        .oe_n   (mem_oe_n),
        .we_n   (mem_we_n),
        .drive  (drive),
        .cap    (cap),
        .adv    (adv)
    );

    bitchain_addr_gen #(.ADDR_W(ADDR_W), .LANES(LANES)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .depth_m1 (depth_m1),
        .addr     (mem_addr),
        .filled   (filled)
    );

    bitchain_lane_latch #(.LANES(LANES)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (cap),
        .fill_done (filled),
        .in_bit    (in_bit),
        .rd_data   (mem_dq),
        .wr_data   (wr_data),
        .tap_out   (ser_out)
    );

    assign mem_dq = drive ? wr_data : {LANES{1'bz}};

endmodule

// File: rtl/bitchain_delay_chk.sv
module bitchain_delay_chk
    import bitchain_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic [ADDR_W-1:0] depth_m1,
    input logic              ser_out,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input step_state_t       state,
    input logic              drive,
    input logic              filled
);
    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    assert_drive_write_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> (!mem_we_n && mem_oe_n));

    assert_we_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> mem_we_n);

    assert_start_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && bit_en) |=> !mem_oe_n);

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_WRITE) |=> $stable(mem_addr));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |=> (mem_addr == (($past(mem_addr) >= depth_m1) ?
                                 '0 : $past(mem_addr) + 1'b1)));

    assert_fill_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !filled |-> !ser_out);

endmodule

bind bitchain_delay bitchain_delay_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .depth_m1 (depth_m1),
    .ser_out  (ser_out),
    .mem_addr (mem_addr),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .state    (state),
    .drive    (drive),
    .filled   (filled)
);

// File: tb/test_bitchain_delay.sv
`timescale 1ns/1ps
module test_bitchain_delay;
    localparam int AW = 10;
    localparam int LN = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_en = 1'b0;
    logic          ser_in = 1'b0;
    logic [AW-1:0] depth_m1 = '0;
    logic          ser_out;
    logic [AW-1:0] mem_addr;
    wire  [LN-1:0] mem_dq;
    logic          mem_oe_n;
    logic          mem_we_n;

    int   n_chk = 0;
    int   n_fail = 0;
    int   k = 0;
    int   dep = 1;
    logic sent [0:255];
    logic [LN-1:0] sram [0:(1<<AW)-1];

    always #2.5 clk = ~clk;

    bitchain_delay #(.ADDR_W(AW), .LANES(LN)) i_bitchain_delay (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in),
        .depth_m1(depth_m1), .ser_out(ser_out), .mem_addr(mem_addr),
        .mem_dq(mem_dq), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    // Asynchronous-read, clocked-write SRAM model, filled with ones.
    assign mem_dq = (!mem_oe_n && mem_we_n) ? sram[mem_addr] : {LN{1'bz}};
    initial for (int i = 0; i < (1<<AW); i++) sram[i] = '1;
    always @(posedge clk) if (!mem_we_n) sram[mem_addr] <= mem_dq;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (step %0d)", req, act, exp, k);
        end
    endtask

    task automatic do_reset(input int d);
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; ser_in = 1'b0;
        depth_m1 = AW'(d - 1); dep = d; k = 0;
        repeat (3) @(negedge clk);
        check(mem_oe_n && mem_we_n, "R1 strobes in reset", {mem_oe_n, mem_we_n}, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_oe_n && mem_we_n, "R1 strobes", {mem_oe_n, mem_we_n}, 2'b11);
        check(mem_addr == '0, "R1 addr", mem_addr, 0);
        check(ser_out == 1'b0, "R1 ser_out", ser_out, 0);
    endtask

    // One bit period; called on a falling edge with the block idle.
    task automatic do_step(input logic b, input bit hold);
        logic [AW-1:0] a0;
        logic [LN-1:0] rd;
        logic [LN-1:0] exp_wr;
        logic          exp_out;
        int            a_next;
        a0 = mem_addr;
        rd = sram[a0];
        sent[k] = b;
        bit_en = 1'b1; ser_in = b;
        @(negedge clk);
        if (hold) ser_in = ~b; else bit_en = 1'b0;
        check(!mem_oe_n && mem_we_n, "R2 read slot", {mem_oe_n, mem_we_n}, 2'b01);
        check(mem_addr == a0, "R4 read addr", mem_addr, a0);
        @(negedge clk);
        bit_en = 1'b0;
        check(!mem_oe_n && mem_we_n, "R2 capture slot", {mem_oe_n, mem_we_n}, 2'b01);
        @(negedge clk);
        check(mem_oe_n && mem_we_n, "R2 turnaround", {mem_oe_n, mem_we_n}, 2'b11);
        exp_out = (k >= LN*dep) ? sent[k - LN*dep] : 1'b0;
        check(ser_out == exp_out, "R7 delayed bit", ser_out, exp_out);
        if (k >= LN*dep)
            check(ser_out == rd[LN-1], "R5 top lane out", ser_out, rd[LN-1]);
        else
            check(ser_out == 1'b0, "R6 fill gate", ser_out, 0);
        @(negedge clk);
        check(!mem_we_n && mem_oe_n, "R2 write slot", {mem_oe_n, mem_we_n}, 2'b10);
        check(mem_addr == a0, "R4 write addr", mem_addr, a0);
        exp_wr = {rd[LN-2:0], b};
        check(mem_dq == exp_wr, hold ? "R8 late input ignored" : "R3 write byte",
              mem_dq, exp_wr);
        @(negedge clk);
        check(mem_oe_n && mem_we_n, "R2 back to idle", {mem_oe_n, mem_we_n}, 2'b11);
        a_next = (int'(a0) >= dep - 1) ? 0 : int'(a0) + 1;
        check(mem_addr == AW'(a_next), hold ? "R8 single step" : "R4 advance",
              mem_addr, a_next);
        check(ser_out == exp_out, "R5 output held", ser_out, exp_out);
        k++;
    endtask

    task automatic t_impulse();
        do_reset(4);
        for (int i = 0; i < 48; i++) do_step(i == 0, 1'b0);
    endtask

    task automatic t_alternate();
        do_reset(1);
        for (int i = 0; i < 24; i++) do_step(i[0], 1'b0);
    endtask

    task automatic t_lfsr();
        logic [6:0] lf;
        lf = 7'h5a;
        do_reset(7);
        for (int i = 0; i < 80; i++) begin
            do_step(lf[0], 1'b0);
            lf = {lf[5:0], lf[6] ^ lf[5]};
        end
    endtask

    task automatic t_ignore();
        do_reset(2);
        for (int i = 0; i < 30; i++) do_step(i % 3 == 1, (i % 7) == 3);
    endtask

    initial begin
        t_impulse();
        t_alternate();
        t_lfsr();
        t_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule